// File: doc/BRIEF.md
# Multi-channel edge-placement PWM generator

This block generates up to sixteen pulse-width modulated outputs from one shared time base. A prescaler divides the clock into counting ticks, and one period counter steps on each tick and wraps at a programmable limit. Every channel compares that shared count against two positions of its own: one where its output turns on and one where it turns off. Pulses can therefore be placed anywhere in the period, and they can also straddle the wrap point.

Software configures the block through a small register port. It writes with a one-cycle strobe plus address and data, and it reads back combinationally from the addressed register. The period and the per-channel edge positions are staged. In immediate mode the staged values take effect on the next clock. In synchronized mode they wait for the counter to wrap, so a new period and a new set of edges change in the same cycle. The prescale value, the channel enables and the mode bit take effect directly. The register width is a build parameter of 8, 16 or 32 bits.

Top module: `edgepwm_top`

## Requirements
- R1: The period counter advances once every PRESCALE+1 clocks, where PRESCALE is the register at address 0. A value of 0 advances it on every clock.
- R2: The counter runs from 0 up to PERIOD-1 and then returns to 0. PERIOD is the register at address 1. A PERIOD of 0 or 1 keeps the counter at 0.
- R3: The output of channel i is high while the counter value c lies in the window set by the on position A and the off position B. When A<B the window is A<=c<B. When A>B it is c>=A or c<B. The output is registered and reflects the counter value one clock later.
- R4: When the on and off positions of a channel are equal, that output stays low.
- R5: Bit i of address 2 enables channel i for i=0..7, and bit i-8 of address 3 enables channel i for i=8..15. A disabled channel drives a low output from the next clock on. Enable writes act immediately.
- R6: With bit 0 of address 4 clear, a written period or edge position is in force one clock after the write strobe.
- R7: With bit 0 of address 4 set, the in-force period and edge positions change only in the cycle in which the counter wraps. A write that coincides with a wrap waits for the following wrap.
- R8: A read combinationally returns the last value written to the addressed register. The on position of channel i is at address 32+2i and the off position at 33+2i. Enable bits of absent channels, edge addresses of absent channels and unmapped addresses all read 0.
- R9: Reset clears every register, the counter and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Combinational read data of the addressed register |
| pwm_out | output | N_CH | Channel outputs |

## Verification
In synchronized mode, a register write and a counter wrap can land in the same clock. At that point the staged copy is being taken into the in-force copy at the very moment it is being overwritten. The bench predicts the wrap from its own model of the time base and places the write strobe exactly on that cycle. It then counts the high cycles of the affected channel over the next two periods: the first period must still show the old pulse width and only the second the new one. Randomized writes in both modes also keep hitting this coincidence, and a cycle-by-cycle comparison against the bench model judges each of them.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;
  localparam int ADR_PRESC   = 0;
  localparam int ADR_PERIOD  = 1;
  localparam int ADR_EN_LO   = 2;
  localparam int ADR_EN_HI   = 3;
  localparam int ADR_SYNC    = 4;
  localparam int ADR_EDGE0   = 32;
  localparam int EDGE_STRIDE = 2;
  localparam int MAX_CH      = 16;

  // true when the current count is the final one of the period
  function automatic logic at_last(input logic [31:0] c, input logic [31:0] p);
    return (33'(c) + 33'd1) >= 33'(p);
  endfunction

  // on/off window test; equal positions give an empty window
  function automatic logic in_window(input logic [31:0] c, input logic [31:0] on_pos,
                                     input logic [31:0] off_pos);
    if (on_pos == off_pos)     return 1'b0;
    else if (on_pos < off_pos) return (c >= on_pos) && (c < off_pos);
    else                       return (c >= on_pos) || (c < off_pos);
  endfunction
endpackage

// File: rtl/edgepwm_timebase.sv
module edgepwm_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] presc,
  input  logic [W-1:0] period,
  output logic         tick,
  output logic         wrap,
  output logic [W-1:0] cnt
);
  logic [W-1:0] pcnt;

  assign tick = (pcnt >= presc);
  assign wrap = tick && edgepwm_pkg::at_last(32'(cnt), 32'(period));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      cnt  <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/edgepwm_regs.sv
module edgepwm_regs #(
  parameter int N_CH   = 16,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic                        wrap,
  output logic [REG_W-1:0]            rdata,
  output logic [REG_W-1:0]            presc,
  output logic [REG_W-1:0]            period_shd,
  output logic [REG_W-1:0]            period_act,
  output logic [N_CH-1:0][REG_W-1:0]  on_act,
  output logic [N_CH-1:0][REG_W-1:0]  off_act,
  output logic [N_CH-1:0]             en_vec,
  output logic                        sync_en
);
  import edgepwm_pkg::*;

  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((17'd1 << N_CH) - 17'd1);

  logic [N_CH-1:0][REG_W-1:0] on_shd, off_shd;
  logic [MAX_CH-1:0]          en_q;
  logic                       take;

  // staged values move into force every clock in immediate mode, else at wrap
  assign take   = !sync_en || wrap;
  assign en_vec = en_q[N_CH-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc      <= '0;
      period_shd <= '0;
      period_act <= '0;
      en_q       <= '0;
      sync_en    <= 1'b0;
    end else begin
      if (take) period_act <= period_shd;
      if (wr_en) begin
        case (int'(addr))
          ADR_PRESC:  presc      <= wdata;
          ADR_PERIOD: period_shd <= wdata;
          ADR_EN_LO:  en_q[7:0]  <= wdata[7:0] & CH_MASK[7:0];
          ADR_EN_HI:  en_q[15:8] <= wdata[7:0] & CH_MASK[15:8];
          ADR_SYNC:   sync_en    <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_edge
    localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(ADR_EDGE0 + EDGE_STRIDE*i);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(ADR_EDGE0 + EDGE_STRIDE*i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_shd[i]  <= '0;
        off_shd[i] <= '0;
        on_act[i]  <= '0;
        off_act[i] <= '0;
      end else begin
        if (take) begin
          on_act[i]  <= on_shd[i];
          off_act[i] <= off_shd[i];
        end
        if (wr_en && addr == A_ON)  on_shd[i]  <= wdata;
        if (wr_en && addr == A_OFF) off_shd[i] <= wdata;
      end
    end
  end

  always_comb begin
    int a;
    int ch;
    a     = int'(addr);
    ch    = (a - ADR_EDGE0) / EDGE_STRIDE;
    rdata = '0;
    case (a)
      ADR_PRESC:  rdata = presc;
      ADR_PERIOD: rdata = period_shd;
      ADR_EN_LO:  rdata = REG_W'(en_q[7:0]);
      ADR_EN_HI:  rdata = REG_W'(en_q[15:8]);
      ADR_SYNC:   rdata = REG_W'(sync_en);
      default: begin
        if (a >= ADR_EDGE0 && ch < N_CH)
          rdata = addr[0] ? off_shd[ch] : on_shd[ch];
      end
    endcase
  end
endmodule

// File: rtl/edgepwm_chan.sv
module edgepwm_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] on_pos,
  input  logic [W-1:0] off_pos,
  output logic         pwm,
  output logic         eq
);
  assign eq = (on_pos == off_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= en && edgepwm_pkg::in_window(32'(cnt), 32'(on_pos), 32'(off_pos));
  end
endmodule

// File: rtl/edgepwm_top.sv
module edgepwm_top #(
  parameter int N_CH   = 16,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [N_CH-1:0]   pwm_out
);
  logic                       tb_tick, tb_wrap;
  logic [REG_W-1:0]           tb_cnt;
  logic [REG_W-1:0]           presc, period_shd, period_act;
  logic [N_CH-1:0][REG_W-1:0] on_act, off_act;
  logic [N_CH-1:0]            en_vec, eq_mask;
  logic                       sync_en;

  edgepwm_regs #(.N_CH(N_CH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wrap(tb_wrap), .rdata(rdata), .presc(presc), .period_shd(period_shd),
    .period_act(period_act), .on_act(on_act), .off_act(off_act),
    .en_vec(en_vec), .sync_en(sync_en)
  );

  edgepwm_timebase #(.W(REG_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .presc(presc), .period(period_act),
    .tick(tb_tick), .wrap(tb_wrap), .cnt(tb_cnt)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    edgepwm_chan #(.W(REG_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en_vec[i]), .cnt(tb_cnt),
      .on_pos(on_act[i]), .off_pos(off_act[i]), .pwm(pwm_out[i]), .eq(eq_mask[i])
    );
  end
endmodule

// File: rtl/edgepwm_chk.sv
module edgepwm_chk #(
  parameter int N_CH  = 16,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic [REG_W-1:0] cnt,
  input logic [REG_W-1:0] period_shd,
  input logic [REG_W-1:0] period_act,
  input logic             sync_en,
  input logic [N_CH-1:0]  en_vec,
  input logic [N_CH-1:0]  eq_mask,
  input logic [N_CH-1:0]  pwm_out
);
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  p_equal_edges_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_out & $past(eq_mask)) == '0));

  p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_out & ~$past(en_vec)) == '0));

  p_immediate_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (period_act == $past(period_shd)));

  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !wrap) |=> $stable(period_act));
endmodule

bind edgepwm_top edgepwm_chk #(.N_CH(N_CH), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tb_tick), .wrap(tb_wrap), .cnt(tb_cnt),
  .period_shd(period_shd), .period_act(period_act), .sync_en(sync_en),
  .en_vec(en_vec), .eq_mask(eq_mask), .pwm_out(pwm_out)
);

// File: tb/test_edgepwm_top.sv
module test_edgepwm_top;
  localparam int N  = 6;
  localparam int RW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic [N-1:0]  pwm_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit checking = 0;
  string cur_tag = "R3";

  edgepwm_top #(.N_CH(N), .REG_W(RW), .ADDR_W(AW)) i_edgepwm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  // reference model state
  int unsigned m_pcnt, m_cnt, m_presc, m_per_s, m_per_a;
  int unsigned m_on_s[N], m_on_a[N], m_off_s[N], m_off_a[N];
  logic [15:0] m_en;
  bit          m_sync;
  logic [N-1:0] exp_out;

  function automatic bit lit(int unsigned c, int unsigned a, int unsigned b);
    if (a == b) return 0;
    if (a < b)  return (c >= a) && (c < b);
    return !((c >= b) && (c < a));
  endfunction

  function automatic bit wrap_next();
    return (m_pcnt >= m_presc) && (m_cnt + 1 >= m_per_a);
  endfunction

  function automatic int unsigned exp_rd(int a);
    int ch;
    ch = (a - 32) / 2;
    case (a)
      0: return m_presc;
      1: return m_per_s;
      2: return m_en[7:0];
      3: return m_en[15:8];
      4: return m_sync;
      default: begin
        if (a >= 32 && ch < N) return (a % 2 == 1) ? m_off_s[ch] : m_on_s[ch];
        return 0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pcnt = 0; m_cnt = 0; m_presc = 0; m_per_s = 0; m_per_a = 0;
      m_en = '0; m_sync = 0; exp_out = '0;
      for (int i = 0; i < N; i++) begin
        m_on_s[i] = 0; m_on_a[i] = 0; m_off_s[i] = 0; m_off_a[i] = 0;
      end
    end else begin
      bit tk, wp;
      int a, ch;
      for (int i = 0; i < N; i++) exp_out[i] = m_en[i] && lit(m_cnt, m_on_a[i], m_off_a[i]);
      tk = (m_pcnt >= m_presc);
      wp = tk && (m_cnt + 1 >= m_per_a);
      if (!m_sync || wp) begin
        m_per_a = m_per_s;
        for (int i = 0; i < N; i++) begin m_on_a[i] = m_on_s[i]; m_off_a[i] = m_off_s[i]; end
      end
      if (tk) begin m_pcnt = 0; m_cnt = wp ? 0 : m_cnt + 1; end
      else m_pcnt = m_pcnt + 1;
      if (wr_en) begin
        a = int'(addr);
        ch = (a - 32) / 2;
        case (a)
          0: m_presc = wdata;
          1: m_per_s = wdata;
          2: m_en[7:0] = wdata[7:0] & 8'((1 << N) - 1);
          3: m_en[15:8] = 8'h00;
          4: m_sync = wdata[0];
          default: if (a >= 32 && ch < N) begin
            if (a % 2 == 1) m_off_s[ch] = wdata; else m_on_s[ch] = wdata;
          end
        endcase
      end
    end
  end

  // cycle-by-cycle output comparison
  always @(negedge clk) begin
    if (checking) begin
      compared++;
      if (pwm_out !== exp_out) begin
        mismatched++;
        if (mismatched < 12)
          $display("FAIL %s: pwm_out actual %b expected %b at cycle %0d", cur_tag, pwm_out, exp_out, cycles);
      end
    end
  end

  task automatic chk(string tag, int unsigned act, int unsigned exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(int a, int unsigned d);
    addr = AW'(a); wdata = RW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, int a);
    addr = AW'(a);
    #1;
    chk(tag, rdata, exp_rd(a), $sformatf("read of address %0d", a));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic count_high(string tag, int ch, int n, int exp);
    int s;
    s = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); s += pwm_out[ch]; end
    chk(tag, s, exp, $sformatf("high cycles of channel %0d", ch));
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    mismatched++;
    $display("FAIL watchdog: cycles actual %0d expected below 150000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle(3);
    rst_n = 1'b1;
    // R9: reset state
    chk("R9", pwm_out, 0, "outputs after reset");
    for (int a = 0; a < 5; a++) rd("R9", a);
    rd("R9", 32); rd("R9", 33);
    checking = 1;

    // R1: prescale 2, period 8, window [1,4) -> 3 counts * 3 clocks
    cur_tag = "R1";
    wr(0, 2); wr(1, 8); wr(32, 1); wr(33, 4); wr(2, 6'h01);
    idle(30);
    count_high("R1", 0, 24, 9);

    // R3: window spanning the wrap, prescale 0
    cur_tag = "R3";
    wr(0, 0); wr(40, 6); wr(41, 2); wr(2, 6'h11);
    idle(12);
    count_high("R3", 4, 8, 4);
    count_high("R3", 0, 8, 3);

    // R4: equal positions stay low
    cur_tag = "R4";
    wr(38, 4); wr(39, 4); wr(2, 6'h19);
    idle(12);
    count_high("R4", 3, 16, 0);

    // R5: disable channel 4; absent channels cannot be enabled
    cur_tag = "R5";
    wr(2, 6'h09);
    idle(2);
    count_high("R5", 4, 16, 0);
    wr(3, 8'hFF);
    rd("R8", 3);
    chk("R8", rdata, 0, "enable bits of absent channels");
    wr(2, 8'hFF);
    rd("R8", 2);
    chk("R5", rdata, 8'h3F, "enable readback of present channels");

    // R2: period 1 and 0 keep the counter at 0
    cur_tag = "R2";
    wr(34, 0); wr(35, 1); wr(1, 1);
    idle(4);
    count_high("R2", 1, 10, 10);
    wr(1, 0);
    idle(4);
    count_high("R2", 1, 10, 10);

    // R6 / R8: immediate mode readback and absent or unmapped addresses
    cur_tag = "R6";
    wr(1, 10); wr(33, 7);
    rd("R6", 33); rd("R8", 1);
    rd("R8", 7); rd("R8", 32 + 2*N); rd("R8", 63);
    idle(20);

    // R7: write on the wrap cycle waits a whole period
    cur_tag = "R7";
    wr(4, 1); wr(1, 6); wr(36, 1); wr(37, 3);
    idle(20);
    while (!wrap_next()) @(negedge clk);
    wr(37, 5);
    count_high("R7", 2, 6, 2);
    count_high("R7", 2, 6, 4);
    rd("R7", 37); rd("R8", 4);

    // randomized writes in both modes
    cur_tag = "R3";
    for (int it = 0; it < 400; it++) begin
      int sel, a;
      int unsigned d;
      sel = $urandom % 8;
      case (sel)
        0: begin a = 0; d = $urandom % 4; end
        1: begin a = 1; d = $urandom % 25; end
        2: begin a = 2; d = $urandom % 256; end
        3: begin a = 4; d = $urandom % 2; end
        default: begin a = 32 + ($urandom % (2*N)); d = $urandom % 25; end
      endcase
      if ($urandom % 4 == 0) while (!wrap_next()) @(negedge clk);
      wr(a, d);
      rd("R8", a);
      idle($urandom % 30);
    end

    // R9: reset in the middle of operation
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    chk("R9", pwm_out, 0, "outputs after second reset");
    rd("R9", 1); rd("R9", 2); rd("R9", 33);
    idle(5);
    checking = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule